// File: doc/BRIEF.md
# UART Channel Control Register Bank with Enhanced-Field Write Protection

This block holds the control registers of one UART channel: an enhanced feature byte, an interrupt enable byte, a FIFO control byte, a modem control byte and the two bytes of the baud divisor. Software reaches them through a simple synchronous port. A write strobe, a 3-bit address and a write byte are sampled on the rising clock edge. A combinational read byte returns whatever is stored at the current address.

Two guards protect parts of the bank. The first is the enhanced-enable bit, bit 4 of the enhanced feature byte. While it is clear, writes to certain high-order fields of the interrupt enable, FIFO control and modem control bytes are dropped. The other bits of those bytes still take the new data. The second guard is the sleep-enable bit, bit 4 of the interrupt enable byte. While it is set, both divisor bytes are frozen.

The bank drives the 16-bit divisor, the decoded flow-control enables, the software flow-control option code and the full control bytes to the rest of the channel.

Top module: `uer_reg_bank`

## Requirements
- R1: After reset, every stored byte (addresses 0 to 5) reads 0x00. The divisor output is 0x0000, and every decoded enable is 0.
- R2: Address 0 is the enhanced feature byte, and a write stores all 8 bits as given. Its fields decode as follows: bit 7 is the CTS flow enable, bit 6 the RTS flow enable, bit 5 the special-character detect enable, bit 4 the enhanced-enable, and bits 3:0 the software flow option code.
- R3: While the enhanced-enable is 0, a write to address 1 (interrupt enable) leaves bits 7:4 unchanged and stores bits 3:0.
- R4: While the enhanced-enable is 0, a write to address 2 (FIFO control) leaves bits 5:4 unchanged and stores bits 7:6 and 3:0.
- R5: While the enhanced-enable is 0, a write to address 3 (modem control) leaves bits 7:5 unchanged and stores bits 4:0.
- R6: While the enhanced-enable is 1, writes to addresses 1, 2 and 3 store all 8 bits.
- R7: Address 4 holds divisor bits 7:0 and address 5 holds divisor bits 15:8. An accepted write shows on the divisor output in the cycle after the write edge.
- R8: While interrupt enable bit 4 (sleep) is 1, writes to addresses 4 and 5 are ignored and the divisor output holds its value.
- R9: The read byte always equals the stored byte at the current address, whether or not the last write was blocked. Addresses 6 and 7 read 0x00, and writes to them change nothing.
- R10: The sleep output equals interrupt enable bit 4 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address for both write and read |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Stored byte at addr |
| divisor | output | 16 | Baud divisor, high byte from address 5 |
| cts_flow_en | output | 1 | Enhanced byte bit 7 |
| rts_flow_en | output | 1 | Enhanced byte bit 6 |
| spec_char_en | output | 1 | Enhanced byte bit 5 |
| enh_en | output | 1 | Enhanced byte bit 4 |
| swfc_mode | output | 4 | Enhanced byte bits 3:0 |
| sleep_en | output | 1 | Interrupt enable bit 4 |
| ier_q | output | 8 | Interrupt enable byte |
| fcr_q | output | 8 | FIFO control byte |
| mcr_q | output | 8 | Modem control byte |

## Verification
The assertions check several behaviours on every cycle:
- protected bits hold across a guarded write, and an unguarded write lands whole in the next cycle;
- a locked divisor byte stays stable, and an accepted low-byte write reaches the divisor output;
- unmapped addresses read zero.

Three behaviours can only be shown by the bench's scenarios. One is the order dependence between setting the enhanced-enable and writing a protected field. Another is setting sleep, which is itself a protected bit, and then seeing the divisor freeze. The last is that unprotected bits in the same byte still change while the protected bits are blocked. The bench's per-cycle reference model covers all of these across both guard states.

// File: rtl/uer_regs_pkg.sv
package uer_regs_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 6;
  localparam int DIV_W    = 2 * DATA_W;

  localparam int IDX_EFR = 0;
  localparam int IDX_IER = 1;
  localparam int IDX_FCR = 2;
  localparam int IDX_MCR = 3;
  localparam int IDX_DLO = 4;
  localparam int IDX_DHI = 5;

  localparam int ENH_BIT   = 4;
  localparam int SLEEP_BIT = 4;

  // Bits that only accept writes while the enhanced-enable is set
  function automatic logic [DATA_W-1:0] guard_mask(input int idx);
    case (idx)
      IDX_IER: guard_mask = 8'hF0;
      IDX_FCR: guard_mask = 8'h30;
      IDX_MCR: guard_mask = 8'hE0;
      default: guard_mask = '0;
    endcase
  endfunction

  function automatic logic is_divisor(input int idx);
    is_divisor = (idx == IDX_DLO) || (idx == IDX_DHI);
  endfunction

  // Keep bits set in keep, take the rest from the write byte
  function automatic logic [DATA_W-1:0] merge_keep(input logic [DATA_W-1:0] old_v,
                                                  input logic [DATA_W-1:0] new_v,
                                                  input logic [DATA_W-1:0] keep);
    merge_keep = (old_v & keep) | (new_v & ~keep);
  endfunction
endpackage

// File: rtl/uer_field_reg.sv
module uer_field_reg
  import uer_regs_pkg::*;
#(
  parameter int                W     = DATA_W,
  parameter logic [W-1:0]      GUARD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         lock,
  input  logic         guard_on,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] keep_bits;
  logic [W-1:0] q_next;
  logic         write_open;

  assign keep_bits  = lock ? '1 : (guard_on ? GUARD : '0);
  assign write_open = we && !lock && !guard_on;
  assign q_next     = merge_keep(q, wdata, keep_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= q_next;
  end

  // R3 R4 R5: guarded bits hold, the rest take the write byte
  a_r3_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we && guard_on && !lock) |=> ((q & GUARD) == ($past(q) & GUARD)) &&
                                  ((q & ~GUARD) == ($past(wdata) & ~GUARD)));

  a_r6_open_write: assert property (@(posedge clk) disable iff (!rst_n)
    write_open |=> (q == $past(wdata)));

  a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> $stable(q));
endmodule

// File: rtl/uer_rd_mux.sv
module uer_rd_mux
  import uer_regs_pkg::*;
#(
  parameter int N  = NUM_REGS,
  parameter int W  = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]  sel,
  input  logic [W-1:0]   regs [N],
  output logic [W-1:0]   dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++)
      if (int'(sel) == i) dout = regs[i];
  end
endmodule

// File: rtl/uer_reg_bank.sv
module uer_reg_bank
  import uer_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic              cts_flow_en,
  output logic              rts_flow_en,
  output logic              spec_char_en,
  output logic              enh_en,
  output logic [3:0]        swfc_mode,
  output logic              sleep_en,
  output logic [DATA_W-1:0] ier_q,
  output logic [DATA_W-1:0] fcr_q,
  output logic [DATA_W-1:0] mcr_q
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              enh_now;
  logic              sleep_now;
  logic              addr_mapped;

  assign enh_now     = regs[IDX_EFR][ENH_BIT];
  assign sleep_now   = regs[IDX_IER][SLEEP_BIT];
  assign addr_mapped = int'(addr) < NUM_REGS;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic we_i;
    logic lock_i;
    assign we_i   = wr_en && (int'(addr) == i);
    assign lock_i = is_divisor(i) && sleep_now;
    uer_field_reg #(.W(DATA_W), .GUARD(guard_mask(i))) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we_i),
      .lock     (lock_i),
      .guard_on (!enh_now),
      .wdata    (wdata),
      .q        (regs[i])
    );
  end

  uer_rd_mux #(.N(NUM_REGS), .W(DATA_W), .AW(ADDR_W)) u_rd (
    .sel  (addr),
    .regs (regs),
    .dout (rdata)
  );

  assign divisor      = {regs[IDX_DHI], regs[IDX_DLO]};
  assign cts_flow_en  = regs[IDX_EFR][7];
  assign rts_flow_en  = regs[IDX_EFR][6];
  assign spec_char_en = regs[IDX_EFR][5];
  assign enh_en       = enh_now;
  assign swfc_mode    = regs[IDX_EFR][3:0];
  assign sleep_en     = sleep_now;
  assign ier_q        = regs[IDX_IER];
  assign fcr_q        = regs[IDX_FCR];
  assign mcr_q        = regs[IDX_MCR];

  a_r2_efr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(IDX_EFR)) |=>
      ({cts_flow_en, rts_flow_en, spec_char_en, enh_en, swfc_mode} == $past(wdata)));

  a_r7_div_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(IDX_DLO) && !sleep_en) |=> (divisor[7:0] == $past(wdata)));

  a_r8_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sleep_en && (addr == ADDR_W'(IDX_DLO) || addr == ADDR_W'(IDX_DHI)))
      |=> $stable(divisor));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> (rdata == '0));
endmodule

// File: tb/uer_reg_bank_tb.sv
module uer_reg_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [15:0] divisor;
  logic cts_flow_en, rts_flow_en, spec_char_en, enh_en, sleep_en;
  logic [3:0] swfc_mode;
  logic [7:0] ier_q, fcr_q, mcr_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_efr = 0, m_ier = 0, m_fcr = 0, m_mcr = 0, m_dlo = 0, m_dhi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uer_reg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .divisor(divisor), .cts_flow_en(cts_flow_en),
    .rts_flow_en(rts_flow_en), .spec_char_en(spec_char_en), .enh_en(enh_en),
    .swfc_mode(swfc_mode), .sleep_en(sleep_en), .ier_q(ier_q), .fcr_q(fcr_q),
    .mcr_q(mcr_q)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_efr = 0; m_ier = 0; m_fcr = 0; m_mcr = 0; m_dlo = 0; m_dhi = 0;
    end else if (wr_en) begin
      case (addr)
        3'd0: m_efr = wdata;
        3'd1: m_ier = m_efr[4] ? wdata : {m_ier[7:4], wdata[3:0]};
        3'd2: m_fcr = m_efr[4] ? wdata : {wdata[7:6], m_fcr[5:4], wdata[3:0]};
        3'd3: m_mcr = m_efr[4] ? wdata : {m_mcr[7:5], wdata[4:0]};
        3'd4: if (!m_ier[4]) m_dlo = wdata;
        3'd5: if (!m_ier[4]) m_dhi = wdata;
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_efr;
      3'd1: return m_ier;
      3'd2: return m_fcr;
      3'd3: return m_mcr;
      3'd4: return m_dlo;
      3'd5: return m_dhi;
      default: return 8'h00;
    endcase
  endfunction

  // compare on every falling edge once out of reset
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cts_flow_en, rts_flow_en, spec_char_en, enh_en, swfc_mode} == m_efr,
            "R2 efr fields", {cts_flow_en, rts_flow_en, spec_char_en, enh_en, swfc_mode}, m_efr);
      check(ier_q == m_ier, "R3 R6 ier", ier_q, m_ier);
      check(fcr_q == m_fcr, "R4 R6 fcr", fcr_q, m_fcr);
      check(mcr_q == m_mcr, "R5 R6 mcr", mcr_q, m_mcr);
      check(divisor == {m_dhi, m_dlo}, "R7 R8 divisor", divisor, {m_dhi, m_dlo});
      check(sleep_en == m_ier[4], "R10 sleep", sleep_en, m_ier[4]);
      check(rdata == model_read(addr), "R9 rdata", rdata, model_read(addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #2;
    check(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) peek(3'(a), 8'h00, "R1 reset byte");
    check(divisor == 16'h0000, "R1 divisor", divisor, 0);
    check({cts_flow_en, rts_flow_en, spec_char_en, enh_en} == 4'b0, "R1 enables",
          {cts_flow_en, rts_flow_en, spec_char_en, enh_en}, 0);
    @(posedge clk); #1;
    // R3 R4 R5 guard active
    wr(3'd1, 8'hFF); peek(3'd1, 8'h0F, "R3 ier guarded");
    wr(3'd2, 8'hFF); peek(3'd2, 8'hCF, "R4 fcr guarded");
    wr(3'd3, 8'hFF); peek(3'd3, 8'h1F, "R5 mcr guarded");
    // R7 divisor bytes
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    check(divisor == 16'h1234, "R7 divisor", divisor, 16'h1234);
    // R9 unmapped
    wr(3'd6, 8'hAA); peek(3'd6, 8'h00, "R9 addr6");
    wr(3'd7, 8'h55); peek(3'd7, 8'h00, "R9 addr7");
    // R2 R6 open the guard
    wr(3'd0, 8'hB5);
    check(swfc_mode == 4'h5 && enh_en && cts_flow_en && !rts_flow_en && spec_char_en,
          "R2 decode", {cts_flow_en, rts_flow_en, spec_char_en, enh_en, swfc_mode}, 8'hB5);
    wr(3'd1, 8'hA0); peek(3'd1, 8'hA0, "R6 ier open");
    wr(3'd3, 8'hE0); peek(3'd3, 8'hE0, "R6 mcr open");
    // R8 R10 sleep freezes divisor
    wr(3'd1, 8'h10);
    check(sleep_en == 1'b1, "R10 sleep set", sleep_en, 1);
    wr(3'd4, 8'h99); wr(3'd5, 8'h88);
    check(divisor == 16'h1234, "R8 divisor frozen", divisor, 16'h1234);
    peek(3'd4, 8'h34, "R9 blocked read");
    // close guard while sleeping: ier[7:4] locked, sleep stays
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    check(sleep_en == 1'b1, "R3 sleep kept", sleep_en, 1);
    // random traffic in both guard states
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3'd0 && ($urandom_range(0, 3) != 0)) d[4] = (n / 500) % 2 == 1;
      if ($urandom_range(0, 3) == 0) begin
        addr = a; @(posedge clk); #1;
      end else wr(a, d);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule